// File: doc/BRIEF.md
# NVRAM Header Checksum Engine

A sequential engine that computes a 16-bit checksum over a contiguous byte range of a byte-addressed non-volatile memory. The engine then stores the result back into that same memory. A single-cycle start pulse hands it a base address and a byte count. While it runs, the engine owns a single-port memory interface. Over that port it reads the range in ascending address order and folds the bytes into a running checksum. It then writes the two result bytes to a fixed pair of locations and signals completion.

The bytes are taken as big-endian 16-bit words: the byte at the lower address is the upper half of the word. If the count is odd, the last byte becomes a word whose lower half is zero. The checksum is the MSB-first CRC-16 with generator 0x1021. The engine computes it one byte per cycle with a two-nibble update, so no bit-serial loop is needed. The usual use is to seal a configuration header. A typical case covers addresses 0x00 to 0xF7 and puts the checksum at 0xFC/0xFD.

Top module: `nvcsum_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, no memory access is requested, and crc_o reads 0xFFFF.
- R2: Every accepted start sets the running checksum to 0xFFFF, so rerunning an unchanged range yields the same result.
- R3: The result equals the MSB-first CRC-16 with generator 0x1021, initial value 0xFFFF and no final inversion. It is taken over the bytes in ascending address order, which places the lower-address byte of each pair in bits 15:8 of the word.
- R4: For an odd count, the result equals that of the same range extended by one 0x00 byte.
- R5: Reads (mem_req_o=1, mem_we_o=0) go to the addresses base_i through base_i+count_i-1, ascending and one per cycle, and never outside that range. Read data is taken from mem_rdata_i one cycle after the request.
- R6: The result is written as two back-to-back writes: bits 15:8 to RES_ADDR (default 0xFC) and then bits 7:0 to RES_ADDR+1. No other address is written.
- R7: done_o is a one-cycle pulse in the cycle after the second result write. crc_o holds the result while done_o is high, and busy_o is low by then.
- R8: A start pulse while busy_o is high is ignored: it changes neither the range read nor the result.
- R9: A count of zero reads nothing and writes 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | AW | First byte address of the range |
| count_i | input | AW+1 | Number of bytes in the range |
| busy_o | output | 1 | Engine is running |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 16 | Running / final checksum |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after a read request |

## Verification
The hardest cycle to reach is the one where the last read returns: the final byte is folded in that cycle, and the choice between padding and write-back depends on it. A mistake there shows up only as a slightly wrong checksum. The stimulus therefore pairs each odd range with the same range extended by one zero byte, and compares the two results. It also drives one-byte, two-byte and zero-byte ranges and a range that ends at the top of memory. A second start pulse is injected in the middle of a long run to show that the read trace and the result are unchanged.

// File: rtl/nvcsum_pkg.sv
package nvcsum_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PAD,
        ST_WR_HI,
        ST_WR_LO
    } nvcsum_state_e;

    // One byte of an MSB-first CRC-16 (generator 0x1021) in nibble form.
    function automatic logic [15:0] crc_byte_step(input logic [15:0] c,
                                                  input logic [7:0]  b);
        logic [7:0] t;
        logic [3:0] hi_n;
        logic [3:0] mix_n;
        logic [7:0] x;
        t     = c[15:8] ^ b;
        hi_n  = t[7:4];
        mix_n = t[3:0] ^ t[7:4];
        x     = {hi_n, mix_n};
        return {c[7:0], 8'h00} ^ {x[3:0], 12'h000} ^ {3'b000, x, 5'b00000} ^ {8'h00, x};
    endfunction

endpackage

// File: rtl/nvcsum_fold.sv
module nvcsum_fold
    import nvcsum_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    always_comb begin
        crc_o = crc_byte_step(crc_i, byte_i);
    end
endmodule

// File: rtl/nvcsum_addr.sv
module nvcsum_addr #(
    parameter int AW = 12,
    localparam int CW = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    output logic [AW-1:0] addr_o,
    output logic          empty_o,
    output logic          odd_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic          odd;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load_i) begin
            ag_d.addr = base_i;
            ag_d.left = count_i;
            ag_d.odd  = count_i[0];
        end else if (step_i && (ag_q.left != '0)) begin
            ag_d.addr = ag_q.addr + 1'b1;
            ag_d.left = ag_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ag_q <= '0;
        else         ag_q <= ag_d;
    end

    assign addr_o  = ag_q.addr;
    assign empty_o = (ag_q.left == '0);
    assign odd_o   = ag_q.odd;
endmodule

// File: rtl/nvcsum_engine.sv
module nvcsum_engine
    import nvcsum_pkg::*;
#(
    parameter int          AW       = 12,
    parameter logic [11:0] RES_ADDR = 12'h0FC,
    localparam int         CW       = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [15:0]   crc_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i
);
    localparam logic [AW-1:0] RES_HI = AW'(RES_ADDR);
    localparam logic [AW-1:0] RES_LO = AW'(RES_ADDR) + 1'b1;

    typedef struct packed {
        nvcsum_state_e st;
        logic [15:0]   crc;
        logic          pend;
        logic          done;
    } eng_t;

    eng_t e_d, e_q;

    logic          ag_load, ag_step, ag_empty, ag_odd;
    logic [AW-1:0] ag_addr;
    logic [7:0]    fold_byte;
    logic [15:0]   fold_crc;

    nvcsum_addr #(.AW(AW)) u_addr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (ag_load),
        .step_i  (ag_step),
        .base_i  (base_i),
        .count_i (count_i),
        .addr_o  (ag_addr),
        .empty_o (ag_empty),
        .odd_o   (ag_odd)
    );

    assign fold_byte = (e_q.st == ST_PAD) ? 8'h00 : mem_rdata_i;

    nvcsum_fold u_fold (
        .crc_i  (e_q.crc),
        .byte_i (fold_byte),
        .crc_o  (fold_crc)
    );

    always_comb begin
        e_d         = e_q;
        e_d.done    = 1'b0;
        e_d.pend    = 1'b0;
        ag_load     = 1'b0;
        ag_step     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ag_addr;
        mem_wdata_o = 8'h00;
        unique case (e_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ag_load = 1'b1;
                    e_d.crc = CRC_SEED;
                    e_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                if (e_q.pend) e_d.crc = fold_crc;
                if (!ag_empty) begin
                    mem_req_o = 1'b1;
                    ag_step   = 1'b1;
                    e_d.pend  = 1'b1;
                end else begin
                    e_d.st = ag_odd ? ST_PAD : ST_WR_HI;
                end
            end
            ST_PAD: begin
                e_d.crc = fold_crc;
                e_d.st  = ST_WR_HI;
            end
            ST_WR_HI: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = RES_HI;
                mem_wdata_o = e_q.crc[15:8];
                e_d.st      = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = RES_LO;
                mem_wdata_o = e_q.crc[7:0];
                e_d.done    = 1'b1;
                e_d.st      = ST_IDLE;
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            e_q.st   <= ST_IDLE;
            e_q.crc  <= CRC_SEED;
            e_q.pend <= 1'b0;
            e_q.done <= 1'b0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy_o = (e_q.st != ST_IDLE);
    assign done_o = e_q.done;
    assign crc_o  = e_q.crc;
endmodule

// File: rtl/nvcsum_checker.sv
module nvcsum_checker #(
    parameter int          AW       = 12,
    parameter logic [11:0] RES_ADDR = 12'h0FC,
    localparam int         CW       = AW + 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic [AW-1:0] base_i,
    input logic [CW-1:0] count_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [15:0]   crc_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o
);
    localparam logic [AW-1:0] RES_HI = AW'(RES_ADDR);
    localparam logic [AW-1:0] RES_LO = AW'(RES_ADDR) + 1'b1;

    logic [CW:0] lo_q, hi_q;
    logic        rd, wr;

    assign rd = mem_req_o && !mem_we_o;
    assign wr = mem_req_o && mem_we_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (start_i && !busy_o) begin
            lo_q <= (CW+1)'(base_i);
            hi_q <= (CW+1)'(base_i) + (CW+1)'(count_i);
        end
    end

    assert_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (crc_o == 16'hFFFF));

    assert_read_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd |-> (((CW+1)'(mem_addr_o) >= lo_q) && ((CW+1)'(mem_addr_o) < hi_q)));

    assert_read_ascending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd && $past(rd)) |-> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

    assert_write_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr |-> ((mem_addr_o == RES_HI) || (mem_addr_o == RES_LO)));

    assert_write_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && mem_addr_o == RES_HI) |=> (wr && mem_addr_o == RES_LO));

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(wr) && $past(mem_addr_o) == RES_LO && !busy_o));

    assert_quiet_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o);
endmodule

bind nvcsum_engine nvcsum_checker #(.AW(AW), .RES_ADDR(RES_ADDR)) u_nvcsum_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (base_i),
    .count_i    (count_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .crc_o      (crc_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/nvcsum_engine_bench.sv
module nvcsum_engine_bench;
    localparam int AW    = 12;
    localparam int CW    = AW + 1;
    localparam int MSIZE = 1 << AW;
    localparam int NVEC  = 8;

    // {base[15:0], count[13:0], pattern[1:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 14'd248, 2'd0},
        {16'h0000, 14'd248, 2'd1},
        {16'h0100, 14'd1,   2'd0},
        {16'h0101, 14'd7,   2'd3},
        {16'h0200, 14'd2,   2'd2},
        {16'h0300, 14'd0,   2'd0},
        {16'h0FF0, 14'd16,  2'd0},
        {16'h0400, 14'd33,  2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [CW-1:0] count = '0;
    logic          busy, done, req, we;
    logic [15:0]   crc;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata = 8'h00;

    logic [7:0] mem [MSIZE];

    int checks = 0, fails = 0, cycles = 0;
    int rd_cnt = 0, rd_bad = 0, dn_cnt = 0, exp_next = 0;

    always #10 clk = ~clk;

    nvcsum_engine #(.AW(AW)) u_nvcsum_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .count_i(count),
        .busy_o(busy), .done_o(done), .crc_o(crc),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata)
    );

    always @(posedge clk) begin
        if (req && !we) rdata <= mem[addr];
        if (req && we)  mem[addr] <= wdata;
    end

    always @(negedge clk) begin
        if (req && !we) begin
            if (int'(addr) != exp_next) rd_bad++;
            exp_next++;
            rd_cnt++;
        end
        if (done) dn_cnt++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int p, input int a);
        case (p)
            0:       return 8'((a * 7) + 3);
            1:       return 8'hFF;
            2:       return 8'h00;
            default: return a[0] ? 8'h5A : 8'hA5;
        endcase
    endfunction

    task automatic fill(input int p);
        for (int a = 0; a < MSIZE; a++) mem[a] = pat_byte(p, a);
    endtask

    // Bitwise reference: MSB first, generator 0x1021, seed 0xFFFF, zero pad on odd.
    function automatic logic [15:0] ref_crc(input int b, input int n);
        logic [15:0] c = 16'hFFFF;
        int total = n + (n % 2);
        for (int i = 0; i < total; i++) begin
            logic [7:0] d = (i < n) ? mem[b + i] : 8'h00;
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[15] ^ d[k];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    // Runs one computation; optional second start at cycle 'poke_at' (0 = none).
    task automatic run(input int b, input int n, input int poke_at, output logic [15:0] res);
        int k = 0;
        @(negedge clk);
        base = AW'(b); count = CW'(n);
        rd_cnt = 0; rd_bad = 0; dn_cnt = 0; exp_next = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
            if (poke_at != 0 && k == poke_at) begin
                base = AW'(12'h400); count = CW'(3); start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                k++;
            end
        end
        res = crc;
        chk("R7 done seen", {31'd0, done}, 32'd1);
        chk("R7 busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
        chk("R5 read count", rd_cnt, n);
        chk("R5 read order", rd_bad, 0);
    endtask

    initial begin
        logic [15:0] r, r2, expv;
        fill(0);
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 req", {31'd0, req}, 32'd0);
        chk("R1 crc", {16'd0, crc}, 32'hFFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", {31'd0, req}, 32'd0);

        // Vector table walk (R3, R5, R6, R9)
        for (int v = 0; v < NVEC; v++) begin
            int vb = int'(VEC[v][31:16]);
            int vn = int'(VEC[v][15:2]);
            int vp = int'(VEC[v][1:0]);
            fill(vp);
            expv = ref_crc(vb, vn);
            run(vb, vn, 0, r);
            chk(vn == 0 ? "R9 empty range" : "R3 checksum", {16'd0, r}, {16'd0, expv});
            chk("R6 high byte", {24'd0, mem[12'h0FC]}, {24'd0, expv[15:8]});
            chk("R6 low byte", {24'd0, mem[12'h0FD]}, {24'd0, expv[7:0]});
        end

        // R4: odd range equals the same range plus an explicit zero byte
        fill(0);
        mem[12'h50B] = 8'h00;
        run(12'h500, 11, 0, r);
        run(12'h500, 12, 0, r2);
        chk("R4 odd pad matches zero-extended", {16'd0, r}, {16'd0, r2});
        mem[12'h601] = 8'h00;
        run(12'h600, 1, 0, r);
        run(12'h600, 2, 0, r2);
        chk("R4 single byte pad", {16'd0, r}, {16'd0, r2});

        // R2: rerun gives identical result (seed restored)
        fill(3);
        run(12'h020, 40, 0, r);
        run(12'h020, 40, 0, r2);
        chk("R2 rerun stable", {16'd0, r2}, {16'd0, r});
        chk("R2 rerun vs model", {16'd0, r2}, {16'd0, ref_crc(12'h020, 40)});

        // R8: start while busy is ignored
        fill(0);
        expv = ref_crc(0, 248);
        run(0, 248, 20, r);
        chk("R8 result unchanged", {16'd0, r}, {16'd0, expv});
        chk("R8 single done", dn_cnt, 1);
        repeat (5) @(negedge clk);
        chk("R8 no restart", {31'd0, busy}, 32'd0);

        summary();
        $finish;
    end
endmodule